// File: doc/BRIEF.md
# Snoop-Gated DRAM Cycle Launcher

This block sits between a local processor bus and a DRAM timing engine. For each request it decides two moments: when the DRAM access may begin, and when read data may be driven onto the local bus and the transfer terminated. Two handshakes gate those moments. The first is a snoop-busy indication (`mi_n`, active low), which matters only for requests that are snooped. The second is a lock request paired with a lock grant. A configuration wait bit selects between two policies. In the strict policy, the DRAM access waits for every pending handshake. In the speculative policy, a read launches at once and only the data drive and the termination are held back.

The DRAM engine is modelled as a pulse on `dram_start` answered later by a `dram_done` pulse, with `dram_err` qualifying that pulse. A completion that arrives before the handshakes resolve is remembered. The termination then fires when the last gate opens. A two-bit control register sits at one byte address. It holds the wait bit and a spare read/write bit.

Top module: `snoop_dram_launcher`

## Requirements
- R1: After reset `dram_start` and `data_oe` are 0, `ta_n` and `tea_n` are 1, and the control register reads 0, so the wait bit starts clear.
- R2: With the wait bit set, a snooped request (`snp_inh`=0) does not raise `dram_start` while `mi_n` is low. `dram_start` rises one cycle after the clock edge at which `mi_n` is seen high.
- R3: With the wait bit clear, a snooped read raises `dram_start` in the cycle after the request, even while `mi_n` is low.
- R4: For a snooped request, `ta_n`, `tea_n` and `data_oe` stay inactive until `mi_n` has been sampled high, whatever the wait bit is.
- R5: With the wait bit set, a locked request (`lock_req`=1) does not raise `dram_start` until `lock_ok` is sampled high.
- R6: With the wait bit clear, a locked read starts at once, but `ta_n`, `tea_n` and `data_oe` wait until `lock_ok` is sampled high.
- R7: A request with `snp_inh`=1 ignores `mi_n`. It starts and terminates while `mi_n` is low.
- R8: A write always waits for `mi_n` high (if snooped) and for `lock_ok` (if locked) before `dram_start`, even with the wait bit clear.
- R9: Termination needs a `dram_done` pulse and both gates resolved. A `dram_done` that arrives while a gate is still closed is held until the gate opens. A request that is both snooped and locked waits for both gates.
- R10: When `dram_err` accompanies `dram_done`, `tea_n` pulses low in place of `ta_n`, and `ta_n` stays high.
- R11: `ta_n`, `tea_n` and `dram_start` are single-cycle pulses. There is exactly one `dram_start` per accepted request, and the block accepts a new request after termination.
- R12: `data_oe` is 1 only in the termination cycle, and only for reads (`rd_wr`=1).
- R13: The control register sits at byte address 0x2C. Bit 0 is the wait bit and bit 1 is a spare bit. A write with `cfg_we` stores `cfg_wdata` only when `cfg_addr` matches. `cfg_rdata` is loaded one cycle after `cfg_re`, with the register value on a match and 0 otherwise. The spare bit has no effect on gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, one cycle, taken when idle |
| rd_wr | input | 1 | 1 = read, 0 = write, sampled with `req` |
| snp_inh | input | 1 | 1 = snooping inhibited, sampled with `req` |
| mi_n | input | 1 | Snoop busy, active low |
| lock_req | input | 1 | Locked request, sampled with `req` |
| lock_ok | input | 1 | Lock granted |
| dram_done | input | 1 | DRAM engine completion pulse |
| dram_err | input | 1 | Error qualifier for `dram_done` |
| cfg_we | input | 1 | Control register write enable |
| cfg_re | input | 1 | Control register read enable |
| cfg_addr | input | 8 | Control register byte address |
| cfg_wdata | input | 2 | Write data: bit 0 wait, bit 1 spare |
| cfg_rdata | output | 2 | Registered read data |
| dram_start | output | 1 | One-cycle DRAM launch pulse |
| data_oe | output | 1 | Read data drive enable |
| ta_n | output | 1 | Transfer acknowledge, active low |
| tea_n | output | 1 | Transfer error, active low |

## Verification
On every cycle the checker compares the gating rules with its own shadow of the request in flight. No launch may occur under the strict policy while a pending snoop or lock is unresolved. Writes never launch early. Termination and data drive never occur without the required handshakes. Strobes last one cycle, the two termination strobes are exclusive, and data drive appears only on a read termination. Only the directed scenarios can show the positive side of these rules. They show that a speculative read really does launch in the first cycle, that a held completion fires when the last gate opens, that the error path replaces the acknowledge, and that the control register decodes its address and keeps the spare bit.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_BUSY = 2'd2
  } lch_state_e;

  typedef struct packed {
    logic rd;
    logic snooped;
    logic locked;
  } req_attr_t;

endpackage

// File: rtl/sgl_ctrl_reg.sv
module sgl_ctrl_reg #(
  parameter int              AW   = 8,
  parameter logic [AW-1:0]   ADDR = 8'h2C,
  parameter int              DW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          wait_bit
);

  localparam int WAIT_IDX = 0;

  logic          hit;
  logic          reg_en;
  logic          rd_en;
  logic [DW-1:0] reg_q, reg_d;
  logic [DW-1:0] rdata_q, rdata_d;

  assign hit    = (addr == ADDR);
  assign reg_en = we && hit;
  assign rd_en  = re;

  always_comb begin
    reg_d   = wdata;
    rdata_d = hit ? reg_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (reg_en) begin
      reg_q <= reg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign wait_bit = reg_q[WAIT_IDX];

endmodule

// File: rtl/sgl_gate.sv
module sgl_gate
  import sgl_pkg::*;
#(
  parameter bit EARLY_EN = 1'b1
) (
  input  req_attr_t attr,
  input  logic      mi_n,
  input  logic      lock_ok,
  input  logic      wait_bit,
  output logic      start_ok,
  output logic      term_ok
);

  logic snoop_clear;
  logic lock_clear;
  logic all_clear;

  always_comb begin
    snoop_clear = !attr.snooped || mi_n;
    lock_clear  = !attr.locked  || lock_ok;
    all_clear   = snoop_clear && lock_clear;
  end

  assign term_ok = all_clear;

  generate
    if (EARLY_EN) begin : g_early
      // speculative launch only for reads under the relaxed policy
      assign start_ok = all_clear || (attr.rd && !wait_bit);
    end else begin : g_strict
      logic unused_wait;
      assign unused_wait = wait_bit;
      assign start_ok    = all_clear;
    end
  endgenerate

endmodule

// File: rtl/sgl_cycle_fsm.sv
module sgl_cycle_fsm
  import sgl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  req_attr_t attr_in,
  input  logic      start_ok,
  input  logic      term_ok,
  input  logic      dram_done,
  input  logic      dram_err,
  output req_attr_t cur_attr,
  output logic      dram_start,
  output logic      data_oe,
  output logic      ta_n,
  output logic      tea_n
);

  lch_state_e state_q, state_d;
  req_attr_t  attr_q, attr_d;
  logic       attr_en;
  logic       done_q, done_d;
  logic       err_q, err_d;
  logic       done_any, err_any;
  logic       start_q, start_d;
  logic       oe_q, oe_d;
  logic       ta_q, ta_d;
  logic       tea_q, tea_d;

  assign cur_attr = (state_q == ST_IDLE) ? attr_in : attr_q;
  assign attr_en  = (state_q == ST_IDLE) && req;
  assign done_any = done_q || dram_done;
  assign err_any  = err_q  || (dram_done && dram_err);

  always_comb begin
    state_d = state_q;
    attr_d  = attr_in;
    done_d  = done_q;
    err_d   = err_q;
    start_d = 1'b0;
    oe_d    = 1'b0;
    ta_d    = 1'b1;
    tea_d   = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        done_d = 1'b0;
        err_d  = 1'b0;
        if (req) begin
          if (start_ok) begin
            state_d = ST_BUSY;
            start_d = 1'b1;
          end else begin
            state_d = ST_ARM;
          end
        end
      end
      ST_ARM: begin
        if (start_ok) begin
          state_d = ST_BUSY;
          start_d = 1'b1;
        end
      end
      ST_BUSY: begin
        if (done_any && term_ok) begin
          state_d = ST_IDLE;
          oe_d    = attr_q.rd;
          done_d  = 1'b0;
          err_d   = 1'b0;
          if (err_any) tea_d = 1'b0;
          else         ta_d  = 1'b0;
        end else begin
          done_d = done_any;
          err_d  = err_any;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      oe_q    <= 1'b0;
      ta_q    <= 1'b1;
      tea_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      start_q <= start_d;
      oe_q    <= oe_d;
      ta_q    <= ta_d;
      tea_q   <= tea_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
    end else if (attr_en) begin
      attr_q <= attr_d;
    end
  end

  assign dram_start = start_q;
  assign data_oe    = oe_q;
  assign ta_n       = ta_q;
  assign tea_n      = tea_q;

endmodule

// File: rtl/snoop_dram_launcher.sv
module snoop_dram_launcher
  import sgl_pkg::*;
#(
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] CFG_ADDR = 8'h2C,
  parameter int                CFG_DW   = 2,
  parameter bit                EARLY_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rd_wr,
  input  logic              snp_inh,
  input  logic              mi_n,
  input  logic              lock_req,
  input  logic              lock_ok,
  input  logic              dram_done,
  input  logic              dram_err,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              dram_start,
  output logic              data_oe,
  output logic              ta_n,
  output logic              tea_n
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync;
  logic                  wait_bit;
  req_attr_t             attr_in;
  req_attr_t             cur_attr;
  logic                  start_ok;
  logic                  term_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync = rst_pipe[RST_STAGES-1];

  always_comb begin
    attr_in.rd      = rd_wr;
    attr_in.snooped = !snp_inh;
    attr_in.locked  = lock_req;
  end

  sgl_ctrl_reg #(
    .AW   (CFG_AW),
    .ADDR (CFG_ADDR),
    .DW   (CFG_DW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .we       (cfg_we),
    .re       (cfg_re),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .wait_bit (wait_bit)
  );

  sgl_gate #(
    .EARLY_EN (EARLY_EN)
  ) u_gate (
    .attr     (cur_attr),
    .mi_n     (mi_n),
    .lock_ok  (lock_ok),
    .wait_bit (wait_bit),
    .start_ok (start_ok),
    .term_ok  (term_ok)
  );

  sgl_cycle_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync),
    .req        (req),
    .attr_in    (attr_in),
    .start_ok   (start_ok),
    .term_ok    (term_ok),
    .dram_done  (dram_done),
    .dram_err   (dram_err),
    .cur_attr   (cur_attr),
    .dram_start (dram_start),
    .data_oe    (data_oe),
    .ta_n       (ta_n),
    .tea_n      (tea_n)
  );

endmodule

// File: rtl/sgl_launcher_chk.sv
module sgl_launcher_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic rd_wr,
  input logic snp_inh,
  input logic lock_req,
  input logic mi_n,
  input logic lock_ok,
  input logic wait_bit,
  input logic dram_start,
  input logic data_oe,
  input logic ta_n,
  input logic tea_n
);

  logic busy_s, snp_s, lk_s, rd_s;
  logic term_cyc;
  logic take;

  assign term_cyc = !ta_n || !tea_n;
  assign take     = req && (term_cyc || !busy_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_s <= 1'b0;
      snp_s  <= 1'b0;
      lk_s   <= 1'b0;
      rd_s   <= 1'b0;
    end else begin
      busy_s <= term_cyc ? req : (busy_s || req);
      if (take) begin
        snp_s <= !snp_inh;
        lk_s  <= lock_req;
        rd_s  <= rd_wr;
      end
    end
  end

  // R2
  strict_snoop_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_start && snp_s && $past(wait_bit)) |-> $past(mi_n));

  // R5
  strict_lock_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_start && lk_s && $past(wait_bit)) |-> $past(lock_ok));

  // R8
  write_snoop_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_start && !rd_s && snp_s) |-> $past(mi_n));

  // R8
  write_lock_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_start && !rd_s && lk_s) |-> $past(lock_ok));

  // R4
  snoop_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((term_cyc || data_oe) && snp_s) |-> $past(mi_n));

  // R6
  lock_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((term_cyc || data_oe) && lk_s) |-> $past(lock_ok));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ta_n && !tea_n));

  // R11
  ta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> ta_n);

  // R11
  tea_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tea_n |=> tea_n);

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_start |=> !dram_start);

  // R12
  oe_read_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (term_cyc && rd_s));

endmodule

bind snoop_dram_launcher sgl_launcher_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync),
  .req        (req),
  .rd_wr      (rd_wr),
  .snp_inh    (snp_inh),
  .lock_req   (lock_req),
  .mi_n       (mi_n),
  .lock_ok    (lock_ok),
  .wait_bit   (wait_bit),
  .dram_start (dram_start),
  .data_oe    (data_oe),
  .ta_n       (ta_n),
  .tea_n      (tea_n)
);

// File: tb/tb_snoop_dram_launcher.sv
module tb_snoop_dram_launcher;

  localparam logic [7:0] REG_ADDR = 8'h2C;
  localparam logic [7:0] OTHER    = 8'h10;

  logic       clk;
  logic       rst_n;
  logic       req, rd_wr, snp_inh, mi_n, lock_req, lock_ok;
  logic       dram_done, dram_err;
  logic       cfg_we, cfg_re;
  logic [7:0] cfg_addr;
  logic [1:0] cfg_wdata;
  logic [1:0] cfg_rdata;
  logic       dram_start, data_oe, ta_n, tea_n;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_req = 0;
  bit finished = 0;

  snoop_dram_launcher dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_wr(rd_wr), .snp_inh(snp_inh),
    .mi_n(mi_n), .lock_req(lock_req), .lock_ok(lock_ok),
    .dram_done(dram_done), .dram_err(dram_err),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dram_start(dram_start), .data_oe(data_oe), .ta_n(ta_n), .tea_n(tea_n)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  always @(negedge clk) if (rst_n && dram_start) n_start++;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [1:0] d);
    cfg_re = 1'b1; cfg_addr = a;
    step();
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic issue(input logic rd, input logic inh, input logic lk);
    req = 1'b1; rd_wr = rd; snp_inh = inh; lock_req = lk;
    n_req++;
    step();
    req = 1'b0;
  endtask

  task automatic pulse_done(input logic err);
    dram_done = 1'b1; dram_err = err;
    step();
    dram_done = 1'b0; dram_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [1:0] v;
    chk("R1 dram_start", dram_start, 0);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 ta_n", ta_n, 1);
    chk("R1 tea_n", tea_n, 1);
    cfg_read(REG_ADDR, v);
    chk("R1 cfg reset", v, 0);
  endtask

  task automatic t_cfg();
    logic [1:0] v;
    cfg_write(REG_ADDR, 2'b11);
    cfg_read(REG_ADDR, v);
    chk("R13 readback", v, 3);
    cfg_write(OTHER, 2'b00);
    cfg_read(REG_ADDR, v);
    chk("R13 other addr write ignored", v, 3);
    cfg_read(OTHER, v);
    chk("R13 other addr reads 0", v, 0);
    cfg_write(REG_ADDR, 2'b10);
    cfg_read(REG_ADDR, v);
    chk("R13 spare bit kept", v, 2);
  endtask

  task automatic t_early_read();
    int s0 = n_start;
    mi_n = 1'b0;
    issue(1, 0, 0);
    chk("R3 early start", dram_start, 1);
    pulse_done(0);
    chk("R4 ta held", ta_n, 1);
    chk("R4 oe held", data_oe, 0);
    step(); step();
    chk("R9 done held", ta_n, 1);
    mi_n = 1'b1;
    step();
    chk("R4 ta after mi", ta_n, 0);
    chk("R12 oe read", data_oe, 1);
    chk("R10 tea idle", tea_n, 1);
    step();
    chk("R11 ta pulse", ta_n, 1);
    chk("R12 oe drops", data_oe, 0);
    chk("R11 one start", n_start - s0, 1);
  endtask

  task automatic t_wait_snoop();
    cfg_write(REG_ADDR, 2'b01);
    mi_n = 1'b0;
    issue(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2 no start", dram_start, 0);
      step();
    end
    mi_n = 1'b1;
    step();
    chk("R2 start after mi", dram_start, 1);
    pulse_done(0);
    chk("R2 ta", ta_n, 0);
    step();
  endtask

  task automatic t_both();
    mi_n = 1'b0; lock_ok = 1'b0;
    issue(1, 0, 1);
    chk("R9 no start both", dram_start, 0);
    mi_n = 1'b1;
    step();
    chk("R9 lock pending", dram_start, 0);
    lock_ok = 1'b1;
    step();
    chk("R9 start both", dram_start, 1);
    mi_n = 1'b0;
    pulse_done(0);
    chk("R9 ta waits mi", ta_n, 1);
    step();
    chk("R9 ta still waits", ta_n, 1);
    mi_n = 1'b1;
    step();
    chk("R9 ta held done", ta_n, 0);
    step();
    lock_ok = 1'b0;
  endtask

  task automatic t_lock_wait();
    mi_n = 1'b0; lock_ok = 1'b0;
    issue(1, 1, 1);
    chk("R5 no start", dram_start, 0);
    step();
    chk("R5 no start 2", dram_start, 0);
    lock_ok = 1'b1;
    step();
    chk("R5 start after lock", dram_start, 1);
    pulse_done(0);
    chk("R7 ta with mi low", ta_n, 0);
    step();
    lock_ok = 1'b0; mi_n = 1'b1;
  endtask

  task automatic t_lock_early();
    cfg_write(REG_ADDR, 2'b10);
    lock_ok = 1'b0;
    issue(1, 1, 1);
    chk("R6 early start", dram_start, 1);
    pulse_done(0);
    chk("R6 ta held", ta_n, 1);
    chk("R6 oe held", data_oe, 0);
    step();
    lock_ok = 1'b1;
    step();
    chk("R6 ta after lock", ta_n, 0);
    chk("R6 oe after lock", data_oe, 1);
    step();
    lock_ok = 1'b0;
  endtask

  task automatic t_inhibit();
    mi_n = 1'b0;
    issue(0, 1, 0);
    chk("R7 start mi low", dram_start, 1);
    pulse_done(0);
    chk("R7 ta mi low", ta_n, 0);
    chk("R12 no oe write", data_oe, 0);
    step();
    mi_n = 1'b1;
  endtask

  task automatic t_write_wait();
    mi_n = 1'b0;
    issue(0, 0, 0);
    chk("R8 write waits mi", dram_start, 0);
    step();
    chk("R8 write waits mi 2", dram_start, 0);
    mi_n = 1'b1;
    step();
    chk("R8 write start", dram_start, 1);
    pulse_done(0);
    chk("R8 write ta", ta_n, 0);
    step();
    lock_ok = 1'b0;
    issue(0, 1, 1);
    chk("R8 write waits lock", dram_start, 0);
    lock_ok = 1'b1;
    step();
    chk("R8 write start lock", dram_start, 1);
    pulse_done(0);
    chk("R8 write lock ta", ta_n, 0);
    step();
    lock_ok = 1'b0;
  endtask

  task automatic t_error();
    issue(1, 1, 0);
    chk("R10 start", dram_start, 1);
    pulse_done(1);
    chk("R10 tea low", tea_n, 0);
    chk("R10 ta high", ta_n, 1);
    chk("R12 oe on err read", data_oe, 1);
    step();
    chk("R11 tea pulse", tea_n, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; rd_wr = 1'b0; snp_inh = 1'b0; mi_n = 1'b1;
    lock_req = 1'b0; lock_ok = 1'b0; dram_done = 1'b0; dram_err = 1'b0;
    cfg_we = 1'b0; cfg_re = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_cfg();
    t_early_read();
    t_wait_snoop();
    t_both();
    t_lock_wait();
    t_lock_early();
    t_inhibit();
    t_write_wait();
    t_error();
    repeat (2) step();
    chk("R11 start per request", n_start, n_req);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule